// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two data buses, A and B, in both directions. Each direction has its own capture register, its own capture strobe, its own source select and its own drive enable. The value sent to the B side is either whatever is on bus A right now or what the A register last captured. The value sent to the A side is chosen the same way from bus B or the B register. Neither direction changes the data on the way through.

Each bus is modelled as three split signals: an input, an output and an output-enable. The block therefore needs no tri-state pads. The effective value of a bus is the block's own output when the block drives it, and the external input when it does not.

The block runs on one clock. Each capture strobe is checked for a rising level on every clock edge. When both directions forward live data and both are enabled, the two buses form a loop. In that case each bus keeps the value it had on the previous clock, taken from a per-bus hold register, so the loop has no combinational cycle.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is low, both capture registers and both hold registers clear to zero. After reset, any output set to stored mode shows 0x00.
- R2: When `cap_a` is high on a clock edge after being low on the previous edge, the A register loads the effective A-bus value. Holding `cap_a` high on later edges loads nothing more.
- R3: When `cap_b` is high on a clock edge after being low on the previous edge, the B register loads the effective B-bus value. Holding `cap_b` high on later edges loads nothing more.
- R4: Captures happen whatever the state of the selects and enables. This includes a fully isolated block and the bus-hold loop.
- R5: With `sel_ab_stored` low and B driven, `b_out` equals the effective A-bus value in the same cycle.
- R6: With `sel_ab_stored` high and B driven, `b_out` equals the A register contents.
- R7: With `sel_ba_stored` low and A driven, `a_out` equals the effective B-bus value in the same cycle. With `sel_ba_stored` high, `a_out` equals the B register contents.
- R8: `b_oe` follows `en_b` (active high) and `a_oe` follows the inverse of `en_a_n` (active low). A released output reads 0x00.
- R9: With both selects low and both enables active, each output repeats its own bus's value from the previous clock. It keeps that value for as long as the mode lasts, whatever `a_in` and `b_in` do.
- R10: A change of select moves an output directly from one source to the other in the same cycle. No third value appears in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_a | input | 1 | Capture strobe for the A register (rising level) |
| cap_b | input | 1 | Capture strobe for the B register (rising level) |
| sel_ab_stored | input | 1 | A-to-B source: 0 live bus A, 1 A register |
| sel_ba_stored | input | 1 | B-to-A source: 0 live bus B, 1 B register |
| en_b | input | 1 | Drive enable for bus B, active high |
| en_a_n | input | 1 | Drive enable for bus A, active low |
| a_in | input | W | Value placed on bus A by other devices |
| a_out | output | W | Value the block drives onto bus A |
| a_oe | output | 1 | Block drives bus A |
| b_in | input | W | Value placed on bus B by other devices |
| b_out | output | W | Value the block drives onto bus B |
| b_oe | output | 1 | Block drives bus B |

## Verification
The hardest state to reach is the bus-hold loop with a meaningful value already on both buses. Bus A is first loaded from outside while only the A-to-B path is enabled, so both hold registers take that value. The A-side enable is then added while both selects stay live. Over the following cycles the external inputs are changed to show they have no effect. A capture strobe is also pulsed during the loop, and the held value is then read back through stored mode.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  typedef enum logic [1:0] {
    XF_ISOLATED = 2'b00,
    XF_TO_A     = 2'b01,
    XF_TO_B     = 2'b10,
    XF_BOTH     = 2'b11
  } xfer_dir_e;

  function automatic xfer_dir_e dir_of(input logic drv_a, input logic drv_b);
    return xfer_dir_e'({drv_b, drv_a});
  endfunction

  function automatic logic is_hold_loop(input xfer_dir_e d, input logic st_ab,
                                        input logic st_ba);
    return (d == XF_BOTH) && !st_ab && !st_ba;
  endfunction

endpackage

// File: rtl/rb_rise_det.sv
module rb_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/rb_store.sv
module rb_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/rb_route.sv
module rb_route
  import regbus_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] reg_a,
  input  logic [W-1:0] reg_b,
  input  logic [W-1:0] last_a,
  input  logic [W-1:0] last_b,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         st_ab,
  input  logic         st_ba,
  input  logic         drv_a,
  input  logic         drv_b,
  output logic [W-1:0] a_val,
  output logic [W-1:0] b_val,
  output logic [W-1:0] a_eff,
  output logic [W-1:0] b_eff,
  output logic         loop_hold
);
  xfer_dir_e dir;
  logic [W-1:0] side_tmp;

  assign dir       = dir_of(drv_a, drv_b);
  assign loop_hold = is_hold_loop(dir, st_ab, st_ba);

  always_comb begin
    a_val    = b_in;
    b_val    = a_in;
    side_tmp = '0;
    if (loop_hold) begin
      a_val = last_a;
      b_val = last_b;
    end else if (st_ab) begin
      b_val    = reg_a;
      side_tmp = drv_b ? reg_a : b_in;
      a_val    = st_ba ? reg_b : side_tmp;
    end else if (st_ba) begin
      a_val    = reg_b;
      side_tmp = drv_a ? reg_b : a_in;
      b_val    = side_tmp;
    end else begin
      unique case (dir)
        XF_TO_A: begin a_val = b_in; b_val = b_in; end
        XF_TO_B: begin a_val = a_in; b_val = a_in; end
        default: begin a_val = b_in; b_val = a_in; end
      endcase
    end
  end

  assign a_eff = drv_a ? a_val : a_in;
  assign b_eff = drv_b ? b_val : b_in;
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic         sel_ab_stored,
  input  logic         sel_ba_stored,
  input  logic         en_b,
  input  logic         en_a_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  localparam int NSIDE = 2;
  localparam int SA = 0;
  localparam int SB = 1;

  logic               drv_a, drv_b;
  logic [NSIDE-1:0]   strobe, cap_evt;
  logic [W-1:0]       eff   [NSIDE];
  logic [W-1:0]       kept  [NSIDE];
  logic [W-1:0]       last  [NSIDE];
  logic [W-1:0]       a_val, b_val;
  logic [W-1:0]       a_bus_eff, b_bus_eff;
  logic               loop_hold;
  logic               cap_a_evt, cap_b_evt;

  assign drv_a  = ~en_a_n;
  assign drv_b  = en_b;
  assign strobe = {cap_b, cap_a};
  assign eff[SA] = a_bus_eff;
  assign eff[SB] = b_bus_eff;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    rb_rise_det u_rise (
      .clk (clk), .rst_n(rst_n), .lvl(strobe[s]), .rise(cap_evt[s])
    );
    rb_store #(.W(W)) u_cap (
      .clk(clk), .rst_n(rst_n), .ld(cap_evt[s]), .d(eff[s]), .q(kept[s])
    );
    rb_store #(.W(W)) u_hold (
      .clk(clk), .rst_n(rst_n), .ld(1'b1), .d(eff[s]), .q(last[s])
    );
  end

  assign cap_a_evt = cap_evt[SA];
  assign cap_b_evt = cap_evt[SB];

  rb_route #(.W(W)) u_route (
    .reg_a(kept[SA]), .reg_b(kept[SB]), .last_a(last[SA]), .last_b(last[SB]),
    .a_in(a_in), .b_in(b_in), .st_ab(sel_ab_stored), .st_ba(sel_ba_stored),
    .drv_a(drv_a), .drv_b(drv_b), .a_val(a_val), .b_val(b_val),
    .a_eff(a_bus_eff), .b_eff(b_bus_eff), .loop_hold(loop_hold)
  );

  assign a_oe  = drv_a;
  assign b_oe  = drv_b;
  assign a_out = drv_a ? a_val : '0;
  assign b_out = drv_b ? b_val : '0;
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel_ab_stored,
  input logic         cap_a_evt,
  input logic         loop_hold,
  input logic [W-1:0] a_bus_eff,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_out,
  input logic         b_oe
);
  AST_RELEASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_oe) |-> (b_out == '0)); // R8

  AST_SINGLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_a_evt |=> !cap_a_evt); // R2

  AST_CAPTURE_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    cap_a_evt |=> (!(sel_ab_stored && b_oe) || (b_out == $past(a_bus_eff)))); // R2

  AST_STORED_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ab_stored && !cap_a_evt) |=>
      (!(sel_ab_stored && b_oe && $past(b_oe)) || $stable(b_out))); // R6

  AST_LIVE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && !sel_ab_stored && !loop_hold) |-> (b_out == a_bus_eff)); // R5

  AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    loop_hold |=> (!loop_hold || (a_oe && $stable(a_out)))); // R9
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_ab_stored(sel_ab_stored),
  .cap_a_evt(cap_a_evt), .loop_hold(loop_hold), .a_bus_eff(a_bus_eff),
  .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/sim_regbus_xcvr.sv
module sim_regbus_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_a = 0, cap_b = 0, sel_ab_stored = 0, sel_ba_stored = 0;
  logic en_b = 0, en_a_n = 1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int total = 0;
  int bad = 0;

  // reference state
  logic [W-1:0] m_ra = '0, m_rb = '0, m_la = '0, m_lb = '0;
  logic m_pa = 0, m_pb = 0;

  always #10 clk = ~clk;

  regbus_xcvr #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cap_a(cap_a), .cap_b(cap_b),
    .sel_ab_stored(sel_ab_stored), .sel_ba_stored(sel_ba_stored),
    .en_b(en_b), .en_a_n(en_a_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // settle the two buses by repeated passes; the loop keeps its own history
  task automatic model_bus(output logic [W-1:0] ea, output logic [W-1:0] eb);
    logic da, db, nxa, nxb;
    logic [W-1:0] ta, tb;
    da = !en_a_n; db = en_b;
    if (da && db && !sel_ab_stored && !sel_ba_stored) begin
      ea = m_la; eb = m_lb;
      return;
    end
    ea = a_in; eb = b_in;
    for (int k = 0; k < 3; k++) begin
      ta = sel_ba_stored ? m_rb : eb;
      tb = sel_ab_stored ? m_ra : ea;
      nxa = da; nxb = db;
      ea = nxa ? ta : a_in;
      eb = nxb ? tb : b_in;
    end
  endtask

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [W-1:0] ai, input logic [W-1:0] bi,
                      input logic sab, input logic sba, input logic eb_i,
                      input logic ean, input logic ca, input logic cb);
    logic [W-1:0] ea, eb;
    @(negedge clk);
    a_in = ai; b_in = bi; sel_ab_stored = sab; sel_ba_stored = sba;
    en_b = eb_i; en_a_n = ean; cap_a = ca; cap_b = cb;
    #2;
    model_bus(ea, eb);
    check(req, "a_oe", {7'd0, a_oe}, {7'd0, !en_a_n});
    check(req, "b_oe", {7'd0, b_oe}, {7'd0, en_b});
    check(req, "a_out", a_out, (!en_a_n) ? ea : '0);
    check(req, "b_out", b_out, en_b ? eb : '0);
    @(posedge clk);
    if (ca && !m_pa) m_ra = ea;
    if (cb && !m_pb) m_rb = eb;
    m_pa = ca; m_pb = cb;
    m_la = ea; m_lb = eb;
  endtask

  initial begin
    #(20 * 5000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: stored mode right after reset shows zero
    step("R1", 8'hFF, 8'hEE, 1, 1, 1, 0, 0, 0);
    // R8: isolated, released outputs read zero
    step("R8", 8'h12, 8'h34, 0, 0, 0, 1, 0, 0);
    // R4 R2: capture A while isolated; then strobe held high with new data
    step("R2", 8'h5A, 8'h00, 0, 0, 0, 1, 1, 0);
    step("R2", 8'h11, 8'h00, 0, 0, 0, 1, 1, 0);
    // R3: capture B while isolated
    step("R3", 8'h00, 8'hC3, 1, 1, 0, 1, 0, 1);
    step("R3", 8'h00, 8'h77, 1, 1, 0, 1, 0, 1);
    // R6: stored A to B
    step("R6", 8'h99, 8'h00, 1, 0, 1, 1, 0, 0);
    // R7: stored B to A
    step("R7", 8'h00, 8'h66, 0, 1, 0, 0, 0, 0);
    // R5: live A to B, several patterns
    step("R5", 8'h96, 8'h00, 0, 0, 1, 1, 0, 0);
    step("R5", 8'h01, 8'h00, 0, 0, 1, 1, 0, 0);
    step("R5", 8'hF0, 8'h00, 0, 0, 1, 1, 0, 0);
    // R7: live B to A
    step("R7", 8'h00, 8'h2D, 0, 0, 0, 0, 0, 0);
    step("R7", 8'h00, 8'hB4, 0, 0, 0, 0, 0, 0);
    // R10: flip A-to-B select between live and stored
    step("R10", 8'h3E, 8'h00, 1, 0, 1, 1, 0, 0);
    step("R10", 8'h3E, 8'h00, 0, 0, 1, 1, 0, 0);
    step("R10", 8'h3E, 8'h00, 1, 0, 1, 1, 0, 0);
    // R6 with B register stored while A driven from it, both enabled
    step("R6", 8'h00, 8'h00, 1, 1, 1, 0, 0, 0);
    // R9: load bus A from outside, then close the loop
    step("R9", 8'h3C, 8'hAA, 0, 0, 1, 1, 0, 0);
    step("R9", 8'h81, 8'h42, 0, 0, 1, 0, 0, 0);
    step("R9", 8'h00, 8'hFF, 0, 0, 1, 0, 0, 0);
    // R4: capture both registers during the loop
    step("R4", 8'h55, 8'h0F, 0, 0, 1, 0, 1, 1);
    step("R9", 8'hE7, 8'h18, 0, 0, 1, 0, 0, 0);
    // read back captured held values through stored mode
    step("R4", 8'h00, 8'h00, 1, 1, 1, 0, 0, 0);
    // R8: release both again
    step("R8", 8'h44, 8'h88, 1, 1, 0, 1, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule